// File: doc/BRIEF.md
# Saturating Up-Down Counter Field

This block is one counter-type field of a control and status register. Hardware moves the count up with an increment strobe and down with a decrement strobe. Software can overwrite the count at any time through a write strobe and data word. The step for each direction is set by a parameter. It is either a fixed constant or a value taken from a hardware port whose width has its own parameter.

Each direction can be given a saturation limit. The upper limit stops increments and the lower limit stops decrements, so the count clamps at the limit instead of wrapping. A direction without saturation wraps modulo 2^CNT_W, and that wrap is reported by a one-cycle overflow or underflow pulse. Two level flags give a comparison with a configured level. One is high while the count is at or above the upper level and the other is high while it is at or below the lower level. The bus decoding and the neighbouring register fields are outside this block.

Top module: `updown_sat_field`

## Requirements
- R1: While rstN is low, count is held at RST_VAL (default 0) and ovfPulse and unfPulse are 0; all updates take effect at the next rising clk edge.
- R2: With incEn high (and swWr, decEn low), count rises by the increment step one cycle later; the step is incStep when INC_FROM_PORT=1 and the constant INC_CONST when INC_FROM_PORT=0, in which case incStep is ignored.
- R3: With decEn high (and swWr, incEn low), count falls by the decrement step one cycle later; the step is decStep when DEC_FROM_PORT=1 and DEC_CONST when DEC_FROM_PORT=0, in which case decStep is ignored.
- R4: When incEn and decEn are both high, count changes once by (increment step minus decrement step); a net of zero leaves count unchanged.
- R5: swWr high loads swData into count on the next edge, regardless of incEn and decEn, and raises neither ovfPulse nor unfPulse.
- R6: With INC_SAT_EN=1, an upward update whose result would exceed INC_SAT_LIM sets count to INC_SAT_LIM and raises no ovfPulse.
- R7: With DEC_SAT_EN=1, a downward update whose result would go below DEC_SAT_LIM sets count to DEC_SAT_LIM and raises no unfPulse.
- R8: With INC_SAT_EN=0, an upward update whose result exceeds 2^CNT_W-1 stores the result modulo 2^CNT_W and drives ovfPulse high for exactly that one cycle; ovfPulse and unfPulse are never high together.
- R9: With DEC_SAT_EN=0, a downward update whose result is below 0 stores the result modulo 2^CNT_W and drives unfPulse high for exactly that one cycle.
- R10: incThr is 1 while count >= INC_THR_LVL and decThr is 1 while count <= DEC_THR_LVL; a flag whose enable parameter is 0 stays 0.
- R11: With swWr, incEn and decEn all low, count holds its value whatever incStep and decStep carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| incEn | input | 1 | Increment strobe, active high |
| incStep | input | INC_W | Increment amount when taken from the port |
| decEn | input | 1 | Decrement strobe, active high |
| decStep | input | DEC_W | Decrement amount when taken from the port |
| swWr | input | 1 | Software write strobe |
| swData | input | CNT_W | Value loaded on a software write |
| count | output | CNT_W | Current count |
| ovfPulse | output | 1 | One-cycle pulse on an upward wrap |
| unfPulse | output | 1 | One-cycle pulse on a downward wrap |
| incThr | output | 1 | Count at or above the upper level |
| decThr | output | 1 | Count at or below the lower level |

## Verification
The increment and the decrement strobes can land in the same cycle, and so can a software write and either strobe. The bench drives both strobes together with different port steps, including a net-zero pair and a pair whose net crosses the saturation limit. It then compares the stored count against the single net update. It also raises a software write while both strobes are high and expects the written value with no wrap pulse. Two instances with opposite saturation choices and opposite step sources receive the same stimulus, so each clamp and each wrap is checked against hand-derived values.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  // Result of the datapath comparisons, consumed by the control
  typedef struct packed {
    logic goesUp;     // net update raises the count
    logic goesDown;   // net update lowers the count
    logic overHi;     // raw result above the upper saturation limit
    logic underLo;    // raw result below the lower saturation limit
    logic pastMax;    // raw result does not fit (too large)
    logic belowZero;  // raw result negative
  } cnt_cmp_t;

  // Selection strobes from the control to the datapath
  typedef struct packed {
    logic takeSw;     // load software data
    logic takeHi;     // clamp to upper limit
    logic takeLo;     // clamp to lower limit
    logic takeRaw;    // store raw (possibly wrapped) result
    logic ovf;        // upward wrap happens this cycle
    logic unf;        // downward wrap happens this cycle
  } cnt_strobe_t;

endpackage

// File: rtl/cnt_step_sel.sv
module cnt_step_sel #(
  parameter int unsigned IN_W      = 4,
  parameter int unsigned OUT_W     = 4,
  parameter bit          FROM_PORT = 1'b1,
  parameter int unsigned CONST_VAL = 1
) (
  input  logic             en,
  input  logic [IN_W-1:0]  stepIn,
  output logic [OUT_W-1:0] amt
);

  logic [OUT_W-1:0] stepVal;

  generate
    if (FROM_PORT) begin : g_port
      assign stepVal = OUT_W'(stepIn);
    end else begin : g_const
      logic unusedStep;
      assign unusedStep = ^stepIn;
      assign stepVal    = OUT_W'(CONST_VAL);
    end
  endgenerate

  assign amt = en ? stepVal : '0;

endmodule

// File: rtl/cnt_dp.sv
module cnt_dp
  import cnt_pkg::*;
#(
  parameter int unsigned    CNT_W       = 8,
  parameter int unsigned    STEP_W      = 4,
  parameter logic [CNT_W-1:0] HI_LIM    = '1,
  parameter logic [CNT_W-1:0] LO_LIM    = '0,
  parameter logic [CNT_W-1:0] RST_VAL   = '0,
  parameter bit             INC_THR_EN  = 1'b0,
  parameter logic [CNT_W-1:0] INC_THR_LVL = '1,
  parameter bit             DEC_THR_EN  = 1'b0,
  parameter logic [CNT_W-1:0] DEC_THR_LVL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STEP_W-1:0] incAmt,
  input  logic [STEP_W-1:0] decAmt,
  input  logic [CNT_W-1:0]  swData,
  input  cnt_strobe_t       strobe,
  output logic [CNT_W-1:0]  count,
  output cnt_cmp_t          cmp,
  output logic              incThr,
  output logic              decThr
);

  localparam int unsigned EXT_W  = CNT_W + STEP_W + 2;
  localparam int unsigned CPAD_W = EXT_W - CNT_W;
  localparam int unsigned SPAD_W = EXT_W - STEP_W;

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countD;

  logic signed [EXT_W-1:0] curExt;
  logic signed [EXT_W-1:0] incExt;
  logic signed [EXT_W-1:0] decExt;
  logic signed [EXT_W-1:0] rawExt;
  logic signed [EXT_W-1:0] hiExt;
  logic signed [EXT_W-1:0] loExt;
  logic signed [EXT_W-1:0] maxExt;

  assign curExt = $signed({{CPAD_W{1'b0}}, countQ});
  assign incExt = $signed({{SPAD_W{1'b0}}, incAmt});
  assign decExt = $signed({{SPAD_W{1'b0}}, decAmt});
  assign hiExt  = $signed({{CPAD_W{1'b0}}, HI_LIM});
  assign loExt  = $signed({{CPAD_W{1'b0}}, LO_LIM});
  assign maxExt = $signed({{CPAD_W{1'b0}}, {CNT_W{1'b1}}});

  assign rawExt = curExt + incExt - decExt;

  always_comb begin
    cmp.goesUp    = rawExt > curExt;
    cmp.goesDown  = rawExt < curExt;
    cmp.overHi    = rawExt > hiExt;
    cmp.underLo   = rawExt < loExt;
    cmp.pastMax   = rawExt > maxExt;
    cmp.belowZero = rawExt[EXT_W-1];
  end

  // Next-value selection; the raw slice is the modulo result on a wrap
  always_comb begin
    countD = countQ;
    if (strobe.takeSw) begin
      countD = swData;
    end else if (strobe.takeHi) begin
      countD = HI_LIM;
    end else if (strobe.takeLo) begin
      countD = LO_LIM;
    end else if (strobe.takeRaw) begin
      countD = rawExt[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= RST_VAL;
    end else begin
      countQ <= countD;
    end
  end

  assign count = countQ;

  generate
    if (INC_THR_EN) begin : g_incThr
      assign incThr = countQ >= INC_THR_LVL;
    end else begin : g_noIncThr
      assign incThr = 1'b0;
    end
    if (DEC_THR_EN) begin : g_decThr
      assign decThr = countQ <= DEC_THR_LVL;
    end else begin : g_noDecThr
      assign decThr = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter bit INC_SAT_EN = 1'b1,
  parameter bit DEC_SAT_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        swWr,
  input  cnt_cmp_t    cmp,
  output cnt_strobe_t strobe,
  output logic        ovfPulse,
  output logic        unfPulse
);

  logic incSat;
  logic decSat;

  assign incSat = INC_SAT_EN;
  assign decSat = DEC_SAT_EN;

  always_comb begin
    strobe = '0;
    if (swWr) begin
      strobe.takeSw = 1'b1;
    end else if (cmp.goesUp) begin
      if (incSat && cmp.overHi) begin
        strobe.takeHi = 1'b1;
      end else begin
        strobe.takeRaw = 1'b1;
        strobe.ovf     = cmp.pastMax;
      end
    end else if (cmp.goesDown) begin
      if (decSat && cmp.underLo) begin
        strobe.takeLo = 1'b1;
      end else begin
        strobe.takeRaw = 1'b1;
        strobe.unf     = cmp.belowZero;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
    end else begin
      ovfPulse <= strobe.ovf;
      unfPulse <= strobe.unf;
    end
  end

endmodule

// File: rtl/updown_sat_field.sv
module updown_sat_field
  import cnt_pkg::*;
#(
  parameter int unsigned      CNT_W         = 8,
  parameter logic [CNT_W-1:0] RST_VAL       = '0,
  parameter int unsigned      INC_W         = 4,
  parameter bit               INC_FROM_PORT = 1'b1,
  parameter int unsigned      INC_CONST     = 1,
  parameter int unsigned      DEC_W         = 4,
  parameter bit               DEC_FROM_PORT = 1'b0,
  parameter int unsigned      DEC_CONST     = 3,
  parameter bit               INC_SAT_EN    = 1'b1,
  parameter logic [CNT_W-1:0] INC_SAT_LIM   = 8'd200,
  parameter bit               DEC_SAT_EN    = 1'b0,
  parameter logic [CNT_W-1:0] DEC_SAT_LIM   = '0,
  parameter bit               INC_THR_EN    = 1'b1,
  parameter logic [CNT_W-1:0] INC_THR_LVL   = 8'd100,
  parameter bit               DEC_THR_EN    = 1'b1,
  parameter logic [CNT_W-1:0] DEC_THR_LVL   = 8'd20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incEn,
  input  logic [INC_W-1:0] incStep,
  input  logic             decEn,
  input  logic [DEC_W-1:0] decStep,
  input  logic             swWr,
  input  logic [CNT_W-1:0] swData,
  output logic [CNT_W-1:0] count,
  output logic             ovfPulse,
  output logic             unfPulse,
  output logic             incThr,
  output logic             decThr
);

  localparam int unsigned STEP_W = (INC_W > DEC_W) ? INC_W : DEC_W;

  logic [STEP_W-1:0] incAmt;
  logic [STEP_W-1:0] decAmt;
  cnt_strobe_t       strobe;
  cnt_cmp_t          cmp;

  cnt_step_sel #(
    .IN_W(INC_W), .OUT_W(STEP_W), .FROM_PORT(INC_FROM_PORT), .CONST_VAL(INC_CONST)
  ) u_incSel (
    .en(incEn), .stepIn(incStep), .amt(incAmt)
  );

  cnt_step_sel #(
    .IN_W(DEC_W), .OUT_W(STEP_W), .FROM_PORT(DEC_FROM_PORT), .CONST_VAL(DEC_CONST)
  ) u_decSel (
    .en(decEn), .stepIn(decStep), .amt(decAmt)
  );

  cnt_dp #(
    .CNT_W(CNT_W), .STEP_W(STEP_W), .HI_LIM(INC_SAT_LIM), .LO_LIM(DEC_SAT_LIM),
    .RST_VAL(RST_VAL), .INC_THR_EN(INC_THR_EN), .INC_THR_LVL(INC_THR_LVL),
    .DEC_THR_EN(DEC_THR_EN), .DEC_THR_LVL(DEC_THR_LVL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .incAmt(incAmt), .decAmt(decAmt), .swData(swData),
    .strobe(strobe), .count(count), .cmp(cmp), .incThr(incThr), .decThr(decThr)
  );

  cnt_ctrl #(
    .INC_SAT_EN(INC_SAT_EN), .DEC_SAT_EN(DEC_SAT_EN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .swWr(swWr), .cmp(cmp), .strobe(strobe),
    .ovfPulse(ovfPulse), .unfPulse(unfPulse)
  );

endmodule

// File: rtl/updown_sat_field_chk.sv
module updown_sat_field_chk #(
  parameter int unsigned      CNT_W       = 8,
  parameter bit               INC_SAT_EN  = 1'b1,
  parameter logic [CNT_W-1:0] INC_SAT_LIM = '1,
  parameter bit               DEC_SAT_EN  = 1'b0,
  parameter logic [CNT_W-1:0] DEC_SAT_LIM = '0
) (
  input logic             clk,
  input logic             rstN,
  input logic             incEn,
  input logic             decEn,
  input logic             swWr,
  input logic [CNT_W-1:0] swData,
  input logic [CNT_W-1:0] count,
  input logic             ovfPulse,
  input logic             unfPulse
);

  // R5
  sw_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    swWr |=> (count == $past(swData)) && !ovfPulse && !unfPulse);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!swWr && !incEn && !decEn) |=> $stable(count));

  // R6
  inc_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!swWr && incEn && !decEn && (count <= INC_SAT_LIM) && INC_SAT_EN)
      |=> (count <= INC_SAT_LIM));

  // R7
  dec_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!swWr && decEn && !incEn && (count >= DEC_SAT_LIM) && DEC_SAT_EN)
      |=> (count >= DEC_SAT_LIM));

  // R8
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (count < $past(count)) && !INC_SAT_EN);

  // R9
  unf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfPulse |-> (count > $past(count)) && !DEC_SAT_EN);

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfPulse && unfPulse));

endmodule

bind updown_sat_field updown_sat_field_chk #(
  .CNT_W(CNT_W), .INC_SAT_EN(INC_SAT_EN), .INC_SAT_LIM(INC_SAT_LIM),
  .DEC_SAT_EN(DEC_SAT_EN), .DEC_SAT_LIM(DEC_SAT_LIM)
) u_chk (
  .clk(clk), .rstN(rstN), .incEn(incEn), .decEn(decEn), .swWr(swWr),
  .swData(swData), .count(count), .ovfPulse(ovfPulse), .unfPulse(unfPulse)
);

// File: tb/updown_sat_field_tb.sv
module updown_sat_field_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       incEn = 1'b0;
  logic [3:0] incStep = '0;
  logic       decEn = 1'b0;
  logic [3:0] decStep = '0;
  logic       swWr = 1'b0;
  logic [7:0] swData = '0;

  logic [7:0] count, countA;
  logic ovfPulse, unfPulse, incThr, decThr;
  logic ovfA, unfA, incThrA, decThrA;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  // Default: inc from port, dec constant 3, upper clamp 200, lower wraps,
  // levels 100 / 20
  updown_sat_field u_dut (
    .clk(clk), .rstN(rstN), .incEn(incEn), .incStep(incStep), .decEn(decEn),
    .decStep(decStep), .swWr(swWr), .swData(swData), .count(count),
    .ovfPulse(ovfPulse), .unfPulse(unfPulse), .incThr(incThr), .decThr(decThr)
  );

  // Alternate: inc constant 5 and wraps, dec from 3-bit port, lower clamp 10,
  // no level flags
  updown_sat_field #(
    .INC_FROM_PORT(1'b0), .INC_CONST(5), .DEC_W(3), .DEC_FROM_PORT(1'b1),
    .INC_SAT_EN(1'b0), .DEC_SAT_EN(1'b1), .DEC_SAT_LIM(8'd10),
    .INC_THR_EN(1'b0), .DEC_THR_EN(1'b0)
  ) u_dutAlt (
    .clk(clk), .rstN(rstN), .incEn(incEn), .incStep(incStep), .decEn(decEn),
    .decStep(decStep[2:0]), .swWr(swWr), .swData(swData), .count(countA),
    .ovfPulse(ovfA), .unfPulse(unfA), .incThr(incThrA), .decThr(decThrA)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ie, input logic [3:0] is, input logic de,
                     input logic [3:0] ds, input logic sw, input logic [7:0] sd);
    @(negedge clk);
    incEn = ie; incStep = is; decEn = de; decStep = ds; swWr = sw; swData = sd;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 8'd0);
  endtask

  task automatic load(input logic [7:0] v);
    cyc(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, v);
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 countAlt", countA, 0);
    chk("R1 ovf", ovfPulse, 0);
    chk("R1 unf", unfPulse, 0);
    chk("R10 incThr at 0", incThr, 0);
    chk("R10 decThr at 0", decThr, 1);
    chk("R10 alt flags off", {incThrA, decThrA}, 0);
  endtask

  task automatic t_inc();
    load(8'd50);
    cyc(1'b1, 4'd7, 1'b0, 4'd0, 1'b0, 8'd0);
    chk("R2 port step 7", count, 57);
    chk("R2 const step alt", countA, 55);
    cyc(1'b1, 4'd15, 1'b0, 4'd0, 1'b0, 8'd0);
    chk("R2 port step 15", count, 72);
    chk("R2 const ignores port", countA, 60);
  endtask

  task automatic t_dec();
    load(8'd50);
    cyc(1'b0, 4'd0, 1'b1, 4'd6, 1'b0, 8'd0);
    chk("R3 const step ignores port", count, 47);
    chk("R3 port step 6 alt", countA, 44);
    cyc(1'b0, 4'd0, 1'b1, 4'd2, 1'b0, 8'd0);
    chk("R3 const step again", count, 44);
    chk("R3 port step 2 alt", countA, 42);
  endtask

  task automatic t_both();
    load(8'd100);
    cyc(1'b1, 4'd9, 1'b1, 4'd4, 1'b0, 8'd0);
    chk("R4 net +6", count, 106);
    chk("R4 net +1 alt", countA, 101);
    cyc(1'b1, 4'd3, 1'b1, 4'd5, 1'b0, 8'd0);
    chk("R4 net zero", count, 106);
    chk("R4 net zero pulses", {ovfPulse, unfPulse}, 0);
    load(8'd198);
    cyc(1'b1, 4'd8, 1'b1, 4'd0, 1'b0, 8'd0);
    chk("R4 R6 net crosses limit", count, 200);
  endtask

  task automatic t_sw();
    load(8'd90);
    cyc(1'b1, 4'd15, 1'b1, 4'd7, 1'b1, 8'd30);
    chk("R5 write beats strobes", count, 30);
    chk("R5 write beats strobes alt", countA, 30);
    chk("R5 no pulses", {ovfPulse, unfPulse, ovfA, unfA}, 0);
  endtask

  task automatic t_hold();
    load(8'd30);
    cyc(1'b0, 4'd15, 1'b0, 4'd7, 1'b0, 8'd99);
    cyc(1'b0, 4'd9, 1'b0, 4'd3, 1'b0, 8'd1);
    chk("R11 hold", count, 30);
    chk("R11 hold alt", countA, 30);
  endtask

  task automatic t_incSat();
    load(8'd195);
    cyc(1'b1, 4'd4, 1'b0, 4'd0, 1'b0, 8'd0);
    chk("R6 below limit", count, 199);
    cyc(1'b1, 4'd4, 1'b0, 4'd0, 1'b0, 8'd0);
    chk("R6 clamp", count, 200);
    chk("R6 no ovf", ovfPulse, 0);
    cyc(1'b1, 4'd15, 1'b0, 4'd0, 1'b0, 8'd0);
    chk("R6 stays at limit", count, 200);
  endtask

  task automatic t_ovf();
    load(8'd252);
    cyc(1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 8'd0);
    chk("R8 wrap value", countA, 1);
    chk("R8 ovf pulse", ovfA, 1);
    chk("R8 no unf with ovf", unfA, 0);
    idle();
    chk("R8 pulse one cycle", ovfA, 0);
    chk("R8 count after", countA, 1);
  endtask

  task automatic t_decSat();
    load(8'd14);
    cyc(1'b0, 4'd0, 1'b1, 4'd3, 1'b0, 8'd0);
    chk("R7 above limit", countA, 11);
    cyc(1'b0, 4'd0, 1'b1, 4'd3, 1'b0, 8'd0);
    chk("R7 clamp", countA, 10);
    chk("R7 no unf", unfA, 0);
    cyc(1'b0, 4'd0, 1'b1, 4'd7, 1'b0, 8'd0);
    chk("R7 stays at limit", countA, 10);
  endtask

  task automatic t_unf();
    load(8'd2);
    cyc(1'b0, 4'd0, 1'b1, 4'd0, 1'b0, 8'd0);
    chk("R9 wrap value", count, 255);
    chk("R9 unf pulse", unfPulse, 1);
    idle();
    chk("R9 pulse one cycle", unfPulse, 0);
    chk("R9 count after", count, 255);
  endtask

  task automatic t_thr();
    load(8'd99);
    chk("R10 incThr below", incThr, 0);
    cyc(1'b1, 4'd1, 1'b0, 4'd0, 1'b0, 8'd0);
    chk("R10 incThr at level", incThr, 1);
    load(8'd20);
    chk("R10 decThr at level", decThr, 1);
    load(8'd21);
    chk("R10 decThr above", decThr, 0);
    chk("R10 alt flags off", {incThrA, decThrA}, 0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    t_inc();
    t_dec();
    t_both();
    t_sw();
    t_hold();
    t_incSat();
    t_ovf();
    t_decSat();
    t_unf();
    t_thr();
    finishRun();
  end

endmodule